// File: doc/BRIEF.md
# Multi-Master SCL Clock Merger

This block produces one master's SCL clock on a line that several masters share. The line is open-drain and wired-AND: it reads LOW while any device pulls it down, and HIGH only when every device has let go. The block has an active-high pull output, `scl_pull`. Outside logic turns this into an open-drain driver. The block watches the real line level on `scl_i`, and times its own phases from what it sees on the line rather than from a free-running timer. The result is that every master's clock merges into one shared waveform. The shared LOW lasts as long as the longest LOW among the masters, and the shared HIGH lasts as long as the shortest HIGH among them.

The line input passes through a two-flop synchronizer. Both edges are detected on the synchronized value. The block then emits one-cycle strobes for a bit-level engine: a rising strobe marks the point to sample data, and a falling strobe marks the point where data may change. The LOW and HIGH period lengths are inputs, counted in clock cycles. Each one is captured at the moment its phase begins.

Top module: `mm_scl_sync`

## Requirements
- R1: During and after reset, `scl_pull`, `rise_stb` and `fall_stb` are all 0.
- R2: When running alone with `low_cnt` ≥ 3, the block pulls SCL for exactly `low_cnt` clock cycles in each LOW phase.
- R3: The pull is released only after the low count has elapsed and the synchronized line has shown LOW. As a result, a `low_cnt` below 3 gives a pull of 3 cycles.
- R4: If another device still holds the line LOW after the block's own LOW count ends, the block keeps `scl_pull` at 0 and counts no HIGH time. The merged LOW therefore lasts as long as the other device holds the line.
- R5: HIGH counting starts only when the synchronized line shows HIGH. When the block releases the line itself, the line stays HIGH for `high_cnt`+3 cycles. When another device releases the line last, it stays HIGH for `high_cnt`+2 cycles.
- R6: If the line falls while the HIGH count is still running, the block abandons the HIGH phase. It then asserts `scl_pull` in the third cycle after the fall and holds it for a full `low_cnt`.
- R7: While `en` is 0, `scl_pull` is 0 from the next clock edge onward. After `en` returns to 1, `scl_pull` is 1 after the next clock edge.
- R8: `rise_stb` and `fall_stb` each pulse for exactly one cycle per line edge. Each pulse falls in the third cycle after the corresponding line transition.
- R9: `low_cnt` and `high_cnt` are captured when a phase starts. A change in the middle of a phase first takes effect in the next phase of that kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; 0 releases the line and clears the phase state |
| low_cnt | input | CW (16) | LOW phase length in clock cycles |
| high_cnt | input | CW (16) | HIGH phase length in clock cycles |
| scl_i | input | 1 | Raw level read back from the shared SCL line |
| scl_pull | output | 1 | 1 = drive SCL LOW |
| rise_stb | output | 1 | One-cycle strobe on a synchronized rising edge of SCL |
| fall_stb | output | 1 | One-cycle strobe on a synchronized falling edge of SCL |

## Verification
The assertions check the following on every cycle:
- a disabled block never pulls;
- the pull is never released without a synchronized LOW having been seen;
- the HIGH phase continues only while the synchronized line stays HIGH;
- a falling edge during the HIGH count always leads to a pull;
- the two strobes are single-cycle and never overlap.

The exact phase lengths can only be shown by the bench's scenarios. These are the bench scenarios and what each one shows:
- A closed-loop sweep over LOW and HIGH counts checks the pull length, the line-HIGH length and the position of each strobe.
- A second master modelled in the bench holds the line LOW past the block's count, which shows the wait state.
- The same bench master pulls the line during the block's HIGH count, which shows the HIGH phase being cut short.
- A count changed in the middle of a phase shows that the counts are captured only when a phase starts.

// File: rtl/mm_scl_sync.sv
module mm_scl_sync #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] low_cnt,
  input  logic [CW-1:0] high_cnt,
  input  logic          scl_i,
  output logic          scl_pull,
  output logic          rise_stb,
  output logic          fall_stb
);
  localparam logic [1:0] ST_OFF = 2'd0;
  localparam logic [1:0] ST_LO  = 2'd1;
  localparam logic [1:0] ST_WT  = 2'd2;
  localparam logic [1:0] ST_HI  = 2'd3;

  logic [2:0]    shr;
  logic [1:0]    st;
  logic [CW-1:0] cnt;
  logic          line_q, cnt_last;

  assign line_q   = shr[1];
  assign cnt_last = ~|cnt[CW-1:1];
  assign rise_stb = shr[1] & ~shr[2];
  assign fall_stb = ~shr[1] & shr[2];
  assign scl_pull = (st == ST_LO);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) shr <= 3'b111;
    else        shr <= {shr[1:0], scl_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_OFF;
      cnt <= '0;
    end else if (!en) begin
      st  <= ST_OFF;
      cnt <= '0;
    end else begin
      case (st)
        ST_OFF: begin
          st  <= ST_LO;
          cnt <= low_cnt;
        end
        ST_LO: begin
          if (cnt_last && !line_q) st <= ST_WT;
          else if (!cnt_last)      cnt <= cnt - 1'b1;
        end
        ST_WT: begin
          if (line_q) begin
            st  <= ST_HI;
            cnt <= high_cnt;
          end
        end
        default: begin
          if (!line_q || cnt_last) begin
            st  <= ST_LO;
            cnt <= low_cnt;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/mm_scl_sync_chk.sv
module mm_scl_sync_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       scl_pull,
  input logic       rise_stb,
  input logic       fall_stb,
  input logic [1:0] st,
  input logic       line_q
);
  localparam logic [1:0] C_OFF = 2'd0;
  localparam logic [1:0] C_HI  = 2'd3;

  // R7
  en_off_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_pull && st == C_OFF));

  // R3
  low_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_pull) && $past(en)) |-> !$past(line_q));

  // R5
  high_needs_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_HI && $past(st) == C_HI) |-> $past(line_q));

  // R6
  cut_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st == C_HI && fall_stb) |=> scl_pull);

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_stb && fall_stb));

  // R8
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |=> !rise_stb);

  // R8
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |=> !fall_stb);
endmodule

bind mm_scl_sync mm_scl_sync_chk chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .scl_pull(scl_pull),
  .rise_stb(rise_stb), .fall_stb(fall_stb), .st(st), .line_q(line_q)
);

// File: tb/mm_scl_sync_test.sv
`timescale 1ns/1ps
module mm_scl_sync_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [15:0] low_cnt = 16'd4;
  logic [15:0] high_cnt = 16'd2;
  logic        oth_pull = 1'b0;
  logic        scl_pull, rise_stb, fall_stb, scl_line;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;
  assign scl_line = ~(scl_pull | oth_pull);

  mm_scl_sync uut (
    .clk(clk), .rst_n(rst_n), .en(en), .low_cnt(low_cnt), .high_cnt(high_cnt),
    .scl_i(scl_line), .scl_pull(scl_pull), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic to_rise();
    while (scl_line) @(negedge clk);
    while (!scl_line) @(negedge clk);
  endtask

  task automatic to_fall();
    while (!scl_line) @(negedge clk);
    while (scl_line) @(negedge clk);
  endtask

  task automatic period(output int hi, output int lo, output int rpos, output int fpos, output int nstb);
    hi = 0; lo = 0; rpos = 0; fpos = 0; nstb = 0;
    while (scl_line) begin
      hi++;
      if (rise_stb) begin nstb++; if (rpos == 0) rpos = hi; end
      @(negedge clk);
    end
    while (!scl_line) begin
      lo++;
      if (fall_stb) begin nstb++; if (fpos == 0) fpos = lo; end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int hi, lo, rp, fp, ns, n;
    // R1 reset state
    repeat (3) @(negedge clk);
    check(!scl_pull && !rise_stb && !fall_stb, "R1", scl_pull, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!scl_pull && !rise_stb && !fall_stb, "R1", scl_pull, 0);

    // R2 R5 R8 sweep, running alone
    en = 1'b1;
    for (int l = 3; l <= 6; l++) begin
      for (int h = 1; h <= 4; h++) begin
        low_cnt = 16'(l); high_cnt = 16'(h);
        to_rise(); to_rise();
        period(hi, lo, rp, fp, ns);
        check(lo == l, "R2", lo, l);
        check(hi == h + 3, "R5", hi, h + 3);
        check(rp == 3 && fp == 3, "R8", rp * 10 + fp, 33);
        check(ns == 2, "R8", ns, 2);
      end
    end

    // R3 short low counts stretch to three cycles
    for (int l = 1; l <= 2; l++) begin
      low_cnt = 16'(l); high_cnt = 16'd2;
      to_rise(); to_rise();
      period(hi, lo, rp, fp, ns);
      check(lo == 3, "R3", lo, 3);
    end

    // R9 counts captured at phase start
    low_cnt = 16'd4; high_cnt = 16'd2;
    to_rise(); to_rise();
    to_fall();
    low_cnt = 16'd9;
    n = 0;
    while (!scl_line) begin n++; @(negedge clk); end
    check(n == 4, "R9", n, 4);
    period(hi, lo, rp, fp, ns);
    check(lo == 9, "R9", lo, 9);

    // R4 another master holds the line low past our count
    low_cnt = 16'd4; high_cnt = 16'd3;
    to_rise(); to_rise();
    to_fall();
    oth_pull = 1'b1;
    for (int s = 1; s < 12; s++) @(negedge clk);
    check(!scl_pull, "R4", scl_pull, 0);
    oth_pull = 1'b0;
    @(negedge clk);
    period(hi, lo, rp, fp, ns);
    check(hi == 3 + 2, "R4", hi, 5);

    // R6 HIGH phase cut short by another master
    low_cnt = 16'd5; high_cnt = 16'd10;
    for (int j = 3; j <= 7; j++) begin
      to_rise(); to_rise();
      for (int s = 1; s < j; s++) @(negedge clk);
      oth_pull = 1'b1;
      @(negedge clk);
      check(!scl_pull, "R6", scl_pull, 0);
      @(negedge clk);
      check(!scl_pull, "R6", scl_pull, 0);
      @(negedge clk);
      check(scl_pull, "R6", scl_pull, 1);
      oth_pull = 1'b0;
      n = 0;
      while (scl_pull) begin n++; @(negedge clk); end
      check(n == 5, "R6", n, 5);
    end

    // R7 enable off and back on
    to_fall();
    en = 1'b0;
    @(negedge clk);
    check(!scl_pull, "R7", scl_pull, 0);
    n = 0;
    for (int s = 0; s < 20; s++) begin
      @(negedge clk);
      if (!scl_line) n++;
    end
    check(n == 0, "R7", n, 0);
    en = 1'b1;
    @(negedge clk);
    check(scl_pull, "R7", scl_pull, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule